// File: doc/BRIEF.md
# Masked Pattern Detector with Accumulator Autoreset

This block is one stage of an arithmetic datapath. It holds a 48-bit accumulator P that adds an incoming addend on every enabled clock. On every load it compares the new accumulator value against a reference pattern. Bit positions selected by a mask are left out of the comparison. Two flags are registered together with P. One says the unmasked bits equal the pattern. The other says they equal the bitwise complement of the pattern. Because the flags load on the same edge as P, they always describe the value currently on the P output.

The pattern and the mask come from elaboration-time choices:

- **Pattern:** either a fixed parameter or the C operand.
- **Mask:** one of four sources:
  - a fixed parameter;
  - the C operand;
  - the inverted C operand shifted left by one place;
  - the inverted C operand shifted left by two places.

The two shifted masks are meant for convergent rounding. The C operand can pass through an optional register so that values derived from it line up with the accumulator.

An autoreset policy can clear P on the edge after a chosen flag condition. The condition is either a match, or the loss of a match. The enable acts as a plain clock enable. The block accepts every presented addend, has no back-pressure and never stalls.

Top module: `pd_accum_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the edge clears `p_out`, `match_out` and `match_inv_out` to 0 (synchronous reset).
- R2: With `ce` high and no autoreset firing, each edge loads `p_out` with (`p_out` + `addend`) mod 2^48. With `ce` low and no autoreset firing, `p_out` and both flags hold.
- R3: A mask bit of 1 excludes that bit position. On each load, `match_out` becomes 1 exactly when every non-excluded bit of the new P equals the pattern bit.
- R4: On each load, `match_inv_out` becomes 1 exactly when every non-excluded bit of the new P equals the inverted pattern bit. The two flags are both 1 only when every bit is excluded.
- R5: The flags load on the same edge as P and are computed from the P value being loaded. This includes the zero loaded by an autoreset.
- R6: `PAT_SRC` = `PAT_FIXED` uses parameter `FIX_PATTERN` (default all zeros). `PAT_SRC` = `PAT_C` uses the effective C value.
- R7: `MASK_SRC` = `MSK_FIXED` uses parameter `FIX_MASK` (default 48'h3fff). `MASK_SRC` = `MSK_C` uses the effective C value.
- R8: `MSK_RND1` uses mask = (~C) << 1 and `MSK_RND2` uses mask = (~C) << 2. The vacated low bits are 0, so those bits are always compared.
- R9: With `C_REG` = 1, the effective C is a register that loads `c_in` on edges where `ce` is high and resets to 0. With `C_REG` = 0, the effective C is `c_in` itself.
- R10: With `AR_MODE` = `AR_MATCH`, while `match_out` is 1 the next edge loads P with 0, whatever the state of `ce`. Autoreset takes priority over accumulation.
- R11: With `AR_MODE` = `AR_LOSS`, the next edge loads P with 0 when `match_out` is 0 now and was 1 one cycle earlier.
- R12: With `AR_MODE` = `AR_NONE`, P is never cleared except by `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Accumulate enable; also loads the optional C register |
| addend | input | 48 | Value added to P when enabled |
| c_in | input | 48 | C operand, source of the pattern and/or the mask |
| p_out | output | 48 | Accumulator value |
| match_out | output | 1 | Unmasked bits of P equal the pattern |
| match_inv_out | output | 1 | Unmasked bits of P equal the inverted pattern |

## Verification
The hardest situation to reach is the loss-of-match autoreset. The flag must be seen high and then low on consecutive cycles, and only then does the next edge clear P. That edge must also reload both flags for zero. The bench reaches it with a rounding-mask configuration and a small C value, so that only the three low bits of P are compared. Small random addends then move P in and out of a match every few cycles, sometimes with the enable dropped, which shows that the clear does not depend on it. A separate phase adds values close to 2^48 to bring P near all ones. This drives the inverted-pattern flag and wraparound, and a reset in mid-run checks recovery.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic {PAT_FIXED, PAT_C} pat_src_e;
  typedef enum logic [1:0] {MSK_FIXED, MSK_C, MSK_RND1, MSK_RND2} mask_src_e;
  typedef enum logic [1:0] {AR_NONE, AR_MATCH, AR_LOSS} ar_mode_e;
endpackage

// File: rtl/pd_c_stage.sv
module pd_c_stage #(
  parameter int W     = 48,
  parameter int C_REG = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] c_eff
);
  logic [W-1:0] c_q;

  always_ff @(posedge clk) begin
    if (rst)     c_q <= '0;
    else if (ce) c_q <= c_in;
  end

  // R9: optional alignment register on the C operand
  always_comb c_eff = (C_REG != 0) ? c_q : c_in;
endmodule

// File: rtl/pd_ref_sel.sv
module pd_ref_sel
  import pd_pkg::*;
#(
  parameter int        W           = 48,
  parameter pat_src_e  PAT_SRC     = PAT_FIXED,
  parameter mask_src_e MASK_SRC    = MSK_FIXED,
  parameter logic [W-1:0] FIX_PATTERN = '0,
  parameter logic [W-1:0] FIX_MASK    = 48'h3fff
) (
  input  logic [W-1:0] c_eff,
  output logic [W-1:0] pattern,
  output logic [W-1:0] mask
);
  logic [W-1:0] c_neg;
  always_comb c_neg = ~c_eff;

  // R6: pattern source
  always_comb pattern = (PAT_SRC == PAT_C) ? c_eff : FIX_PATTERN;

  // R7 / R8: mask source, rounding variants fill vacated low bits with 0
  always_comb begin
    case (MASK_SRC)
      MSK_C:    mask = c_eff;
      MSK_RND1: mask = {c_neg[W-2:0], 1'b0};
      MSK_RND2: mask = {c_neg[W-3:0], 2'b00};
      default:  mask = FIX_MASK;
    endcase
  end
endmodule

// File: rtl/pd_match.sv
module pd_match #(
  parameter int W = 48
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] mask,
  output logic         hit,
  output logic         hit_inv
);
  logic [W-1:0] same_bits;
  logic [W-1:0] diff_bits;

  always_comb begin
    same_bits = ~(value ^ pattern) | mask;
    diff_bits =  (value ^ pattern) | mask;
    hit       = &same_bits;
    hit_inv   = &diff_bits;
  end
endmodule

// File: rtl/pd_accum_detect.sv
module pd_accum_detect
  import pd_pkg::*;
#(
  parameter int        W           = 48,
  parameter int        C_REG       = 1,
  parameter pat_src_e  PAT_SRC     = PAT_FIXED,
  parameter mask_src_e MASK_SRC    = MSK_FIXED,
  parameter ar_mode_e  AR_MODE     = AR_NONE,
  parameter logic [W-1:0] FIX_PATTERN = '0,
  parameter logic [W-1:0] FIX_MASK    = 48'h3fff
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] p_out,
  output logic         match_out,
  output logic         match_inv_out
);
  logic [W-1:0] c_eff, pattern, mask, acc_q, acc_nxt;
  logic         match_q, inv_q, prev_q, fire, load, hit, hit_inv;

  pd_c_stage #(.W(W), .C_REG(C_REG)) u_cstage (
    .clk(clk), .rst(rst), .ce(ce), .c_in(c_in), .c_eff(c_eff)
  );

  pd_ref_sel #(
    .W(W), .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC),
    .FIX_PATTERN(FIX_PATTERN), .FIX_MASK(FIX_MASK)
  ) u_ref (
    .c_eff(c_eff), .pattern(pattern), .mask(mask)
  );

  // R10 / R11 / R12: autoreset condition from the registered flags
  always_comb begin
    case (AR_MODE)
      AR_MATCH: fire = match_q;
      AR_LOSS:  fire = !match_q && prev_q;
      default:  fire = 1'b0;
    endcase
  end

  always_comb begin
    load    = fire || ce;
    acc_nxt = fire ? '0 : acc_q + addend;
  end

  // R5: flags evaluated on the value about to be loaded
  pd_match #(.W(W)) u_match (
    .value(acc_nxt), .pattern(pattern), .mask(mask),
    .hit(hit), .hit_inv(hit_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      match_q <= 1'b0;
      inv_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      prev_q <= match_q;
      if (load) begin
        acc_q   <= acc_nxt;
        match_q <= hit;
        inv_q   <= hit_inv;
      end
    end
  end

  assign p_out         = acc_q;
  assign match_out     = match_q;
  assign match_inv_out = inv_q;
endmodule

// File: rtl/pd_accum_detect_chk.sv
module pd_accum_detect_chk
  import pd_pkg::*;
#(
  parameter int        W        = 48,
  parameter mask_src_e MASK_SRC = MSK_FIXED,
  parameter ar_mode_e  AR_MODE  = AR_NONE,
  parameter logic [W-1:0] FIX_MASK = 48'h3fff
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic [W-1:0] addend,
  input logic [W-1:0] p_out,
  input logic         match_out,
  input logic         match_inv_out
);
  logic seen_prev;
  logic ar_go;

  always_ff @(posedge clk) begin
    if (rst) seen_prev <= 1'b0;
    else     seen_prev <= match_out;
  end

  always_comb begin
    if (AR_MODE == AR_MATCH)     ar_go = match_out;
    else if (AR_MODE == AR_LOSS) ar_go = !match_out && seen_prev;
    else                         ar_go = 1'b0;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (p_out == '0 && !match_out && !match_inv_out));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ce && !ar_go) |=> ($stable(p_out) && $stable(match_out) && $stable(match_inv_out)));

  p_accum_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && !ar_go) |=> (p_out == $past(p_out) + $past(addend)));

  // covers R10 and R11
  p_autoreset_r10: assert property (@(posedge clk) disable iff (rst)
    ar_go |=> (p_out == '0));

  generate
    if ((MASK_SRC == MSK_FIXED && FIX_MASK != '1) ||
        MASK_SRC == MSK_RND1 || MASK_SRC == MSK_RND2) begin : g_excl
      p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(match_out && match_inv_out));
    end
    if (AR_MODE == AR_NONE) begin : g_noar
      p_no_clear_r12: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(p_out));
    end
  endgenerate
endmodule

bind pd_accum_detect pd_accum_detect_chk #(
  .W(W), .MASK_SRC(MASK_SRC), .AR_MODE(AR_MODE), .FIX_MASK(FIX_MASK)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .addend(addend), .p_out(p_out),
  .match_out(match_out), .match_inv_out(match_inv_out)
);

// File: tb/tb_pd_accum_detect.sv
module tb_pd_accum_detect;
  import pd_pkg::*;

  localparam int W = 48;
  localparam int NCFG = 4;
  localparam logic [W-1:0] FPAT = '0;
  localparam logic [W-1:0] FMSK = 48'h3fff;
  // per-configuration settings: pattern src (1=C), mask src (0 fixed,1 C,2 rnd1,3 rnd2),
  // autoreset (0 none,1 match,2 loss), C register
  localparam int PS [NCFG] = '{0, 1, 0, 1};
  localparam int MS [NCFG] = '{0, 1, 2, 3};
  localparam int AR [NCFG] = '{0, 1, 2, 1};
  localparam int CR [NCFG] = '{0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic [W-1:0] addend = '0;
  logic [W-1:0] c_in = '0;
  logic [W-1:0] p [NCFG];
  logic mt [NCFG];
  logic iv [NCFG];

  always #2 clk = ~clk;

  pd_accum_detect #(.C_REG(0), .PAT_SRC(PAT_FIXED), .MASK_SRC(MSK_FIXED), .AR_MODE(AR_NONE))
    dut (.clk(clk), .rst(rst), .ce(ce), .addend(addend), .c_in(c_in),
         .p_out(p[0]), .match_out(mt[0]), .match_inv_out(iv[0]));
  pd_accum_detect #(.C_REG(1), .PAT_SRC(PAT_C), .MASK_SRC(MSK_C), .AR_MODE(AR_MATCH))
    dut_cc (.clk(clk), .rst(rst), .ce(ce), .addend(addend), .c_in(c_in),
            .p_out(p[1]), .match_out(mt[1]), .match_inv_out(iv[1]));
  pd_accum_detect #(.C_REG(0), .PAT_SRC(PAT_FIXED), .MASK_SRC(MSK_RND1), .AR_MODE(AR_LOSS))
    dut_r1 (.clk(clk), .rst(rst), .ce(ce), .addend(addend), .c_in(c_in),
            .p_out(p[2]), .match_out(mt[2]), .match_inv_out(iv[2]));
  pd_accum_detect #(.C_REG(0), .PAT_SRC(PAT_C), .MASK_SRC(MSK_RND2), .AR_MODE(AR_MATCH))
    dut_r2 (.clk(clk), .rst(rst), .ce(ce), .addend(addend), .c_in(c_in),
            .p_out(p[3]), .match_out(mt[3]), .match_inv_out(iv[3]));

  // behavioural reference state
  logic [W-1:0] m_p [NCFG];
  logic [W-1:0] m_cq [NCFG];
  bit m_mt [NCFG];
  bit m_iv [NCFG];
  bit m_prev [NCFG];
  bit was_rst;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    was_rst = rst;
    for (int k = 0; k < NCFG; k++) begin
      logic [W-1:0] ce_v, pat, msk, np;
      bit go, upd, old_mt;
      ce_v = CR[k] ? m_cq[k] : c_in;
      pat  = PS[k] ? ce_v : FPAT;
      case (MS[k])
        1: msk = ce_v;
        2: msk = ~ce_v << 1;
        3: msk = ~ce_v << 2;
        default: msk = FMSK;
      endcase
      go = (AR[k] == 1) ? m_mt[k] : (AR[k] == 2) ? (!m_mt[k] && m_prev[k]) : 1'b0;
      if (rst) begin
        m_p[k] = '0; m_mt[k] = 0; m_iv[k] = 0; m_prev[k] = 0; m_cq[k] = '0;
      end else begin
        old_mt = m_mt[k];
        upd = 1;
        if (go) np = '0;
        else if (ce) np = m_p[k] + addend;
        else begin np = m_p[k]; upd = 0; end
        if (upd) begin
          m_p[k] = np;
          m_mt[k] = 1;
          m_iv[k] = 1;
          for (int b = 0; b < W; b++) begin
            if (!msk[b] && np[b] != pat[b]) m_mt[k] = 0;
            if (!msk[b] && np[b] == pat[b]) m_iv[k] = 0;
          end
        end
        m_prev[k] = old_mt;
        if (ce) m_cq[k] = c_in;
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    if (was_rst) begin
      for (int k = 0; k < NCFG; k++) begin
        chk("R1 reset P", p[k], '0);
        chk("R1 reset match", W'(mt[k]), '0);
        chk("R1 reset inv", W'(iv[k]), '0);
      end
    end else begin
      chk("R2 R12 P cfg0", p[0], m_p[0]);
      chk("R3 match cfg0", W'(mt[0]), W'(m_mt[0]));
      chk("R4 inv cfg0", W'(iv[0]), W'(m_iv[0]));
      chk("R10 P cfg1", p[1], m_p[1]);
      chk("R9 R6 match cfg1", W'(mt[1]), W'(m_mt[1]));
      chk("R7 inv cfg1", W'(iv[1]), W'(m_iv[1]));
      chk("R11 P cfg2", p[2], m_p[2]);
      chk("R8 R5 match cfg2", W'(mt[2]), W'(m_mt[2]));
      chk("R5 inv cfg2", W'(iv[2]), W'(m_iv[2]));
      chk("R10 P cfg3", p[3], m_p[3]);
      chk("R6 R8 match cfg3", W'(mt[3]), W'(m_mt[3]));
      chk("R8 inv cfg3", W'(iv[3]), W'(m_iv[3]));
    end
  endtask

  function automatic logic [W-1:0] rnd48();
    return {$urandom, $urandom} & {W{1'b1}};
  endfunction

  initial begin
    for (int cyc = 0; cyc < 1600; cyc++) begin
      @(negedge clk);
      if (cyc > 0) compare_all();
      rst = (cyc < 3) || (cyc >= 900 && cyc < 902);
      ce  = ($urandom % 4) != 0;
      if (cyc < 500) begin
        addend = W'($urandom % 16);
        case ($urandom % 4)
          0: c_in = 48'h3;
          1: c_in = 48'hF;
          2: c_in = 48'hFFFF_FFFF_FFF0;
          default: c_in = rnd48();
        endcase
      end else if (cyc < 1100) begin
        case ($urandom % 5)
          0: addend = 48'hFFFF_FFFF_C000;
          1: addend = 48'h4000;
          2: addend = 48'hFFFF_FFFF_FFFF;
          3: addend = W'($urandom % 8);
          default: addend = rnd48();
        endcase
        c_in = ($urandom % 2) ? 48'h7 : rnd48();
      end else begin
        addend = ($urandom % 2) ? rnd48() : W'($urandom % 4);
        c_in = rnd48();
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule